// File: doc/BRIEF.md
# Dual-Pair Instruction Prefetch Buffer

This block is the prefetch stage in front of an instruction decoder. It holds four line buffers, and these form two independent pairs. Each buffer holds one 256-bit code-cache line, which is eight fixed-size 32-bit instruction slots. One pair is active: it fills from sequential fetches and feeds the decoder. When a taken branch is predicted, fetching moves to the other pair at the branch target. The decoder keeps draining the active pair, and the pairs swap roles once that pair is empty.

The block sends a line-aligned fetch address to the code cache. The cache answers in the same cycle with `line_valid` and the line data, and a line is taken when both `fetch_req` and `line_valid` are high. Each cycle the decoder sees up to two slots. When it raises `dec_ready` it takes both valid slots. When it also raises `dec_single` it takes only the first slot. A flush strobe empties both pairs and restarts sequential fetch at a recovery address.

Top module: `dual_pair_prefetch`

## Requirements
- R1: After reset both pairs are empty, both slot valids are low, `fetch_req` is high and `fetch_addr` is `boot_addr` with its five low bits cleared.
- R2: Each accepted line adds eight slots to the filling pair and advances `fetch_addr` by 32. Slot k of a line is bits [32k+31:32k], and slot 0 is the oldest.
- R3: `slot0` is the oldest undelivered instruction of the active pair and `slot1` is the one after it, even across the two buffers. A cycle with `dec_ready` high and `dec_single` low removes both valid slots.
- R4: When the active pair holds exactly one instruction, `slot0_valid` is high and `slot1_valid` is low. A cycle with `dec_ready` and `dec_single` both high removes only `slot0`.
- R5: `fetch_req` is low while the filling pair holds more than eight undelivered slots, which means both of its buffers are occupied.
- R6: An accepted `br_taken` makes the other pair the filling pair and sets `fetch_addr` to `br_target` with its five low bits cleared. The active pair keeps delivering its remaining slots.
- R7: While a branch is pending, the branch pair becomes active in the cycle after the active pair is seen empty. Its slots then appear at the outputs.
- R8: `br_taken` is ignored while an earlier branch is still pending. The fetch address and the filling pair stay unchanged.
- R9: `flush` empties both pairs, cancels any pending branch, and holds `fetch_req` low in that cycle. In the next cycle it requests `flush_addr` with its five low bits cleared, into the pair that was active.
- R10: When `flush` and `br_taken` arrive in the same cycle, the flush wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_addr | input | 32 | Fetch address used after reset |
| fetch_req | output | 1 | Fetch request to the code cache |
| fetch_addr | output | 32 | Line-aligned fetch address |
| line_valid | input | 1 | Cache line present for `fetch_addr` |
| line_data | input | 256 | Cache line, eight 32-bit slots |
| br_taken | input | 1 | Predicted-taken branch strobe |
| br_target | input | 32 | Predicted branch target |
| flush | input | 1 | Mispredict or flush strobe |
| flush_addr | input | 32 | Recovery address |
| dec_ready | input | 1 | Decoder takes the offered slots |
| dec_single | input | 1 | Decoder takes only the first slot |
| slot0 | output | 32 | First instruction slot |
| slot0_valid | output | 1 | First slot valid |
| slot1 | output | 32 | Second instruction slot |
| slot1_valid | output | 1 | Second slot valid |

## Verification
The bench drives both buffers of a pair full. A design with the wrong full limit would then overwrite undelivered slots or fetch too early. It drains an odd number of slots so that the pair boundary falls between `slot0` and `slot1`. A wrong read wrap would show a stale second slot, and a wrong one-slot rule would show a false `slot1_valid`. It predicts a branch while the active pair still holds slots, sends a second branch while the first is pending, and then sends a flush together with a branch. A wrong design would swap early and lose sequential slots, jump to the second target, or follow the branch instead of the recovery address.

// File: rtl/dual_pair_prefetch.sv
module dual_pair_prefetch #(
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        boot_addr,
  output logic                     fetch_req,
  output logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     line_valid,
  input  logic [SLOT_W*SLOTS-1:0]  line_data,
  input  logic                     br_taken,
  input  logic [ADDR_W-1:0]        br_target,
  input  logic                     flush,
  input  logic [ADDR_W-1:0]        flush_addr,
  input  logic                     dec_ready,
  input  logic                     dec_single,
  output logic [SLOT_W-1:0]        slot0,
  output logic                     slot0_valid,
  output logic [SLOT_W-1:0]        slot1,
  output logic                     slot1_valid
);
  localparam int LINE_W = SLOT_W * SLOTS;
  localparam int BYTES  = LINE_W / 8;
  localparam int OFF    = $clog2(BYTES);
  localparam int DEPTH  = 2 * SLOTS;
  localparam int PW     = $clog2(DEPTH);
  localparam int CW     = PW + 1;

  logic [SLOT_W-1:0] ring [2][DEPTH];
  logic [PW-1:0]     rd   [2];
  logic              wl   [2];
  logic [CW-1:0]     cnt  [2];
  logic              act, fp, pend;
  logic [ADDR_W-1:0] fa;
  logic [CW-1:0]     take;

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF], {OFF{1'b0}}};
  endfunction

  wire accept = fetch_req & line_valid;
  wire swap   = pend & (cnt[act] == '0);
  wire br_go  = br_taken & ~pend & ~flush;

  assign fetch_req   = ~flush & (cnt[fp] <= CW'(SLOTS));
  assign fetch_addr  = fa;
  assign slot0_valid = cnt[act] != '0;
  assign slot1_valid = cnt[act] > CW'(1);
  assign slot0       = ring[act][rd[act]];
  assign slot1       = ring[act][rd[act] + PW'(1)];

  always_comb begin
    if (!dec_ready || cnt[act] == '0) take = '0;
    else if (dec_single || cnt[act] == CW'(1)) take = CW'(1);
    else take = CW'(2);
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int k = 0; k < SLOTS; k++)
        ring[fp][PW'(int'(wl[fp]) * SLOTS + k)] <= line_data[k*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int p = 0; p < 2; p++) begin
        cnt[p] <= '0;
        rd[p]  <= '0;
        wl[p]  <= 1'b0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        cnt[p] <= cnt[p] + ((accept && fp == 1'(p)) ? CW'(SLOTS) : '0)
                         - ((act == 1'(p)) ? take : '0);
        if (act == 1'(p)) rd[p] <= rd[p] + PW'(take);
        if (accept && fp == 1'(p)) wl[p] <= ~wl[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      fp   <= 1'b0;
      pend <= 1'b0;
      fa   <= align(boot_addr);
    end else if (flush) begin
      pend <= 1'b0;
      fp   <= act;
      fa   <= align(flush_addr);
    end else begin
      if (accept) fa <= fa + ADDR_W'(BYTES);
      if (swap) begin
        act  <= fp;
        pend <= 1'b0;
      end else if (br_go) begin
        fp   <= ~act;
        pend <= 1'b1;
        fa   <= align(br_target);
      end
    end
  end
endmodule

// File: rtl/dual_pair_prefetch_chk.sv
module dual_pair_prefetch_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              line_valid,
  input logic              br_taken,
  input logic              flush,
  input logic [ADDR_W-1:0] flush_addr,
  input logic              slot0_valid,
  input logic              slot1_valid
);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && line_valid && !br_taken) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1 << OFF));

  a_r4_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_valid |-> slot0_valid);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot0_valid && !slot1_valid);

  a_r9_flush_restart: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr[ADDR_W-1:OFF] == $past(flush_addr[ADDR_W-1:OFF]));

  a_r10_flush_over_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && br_taken) |=> fetch_addr[OFF-1:0] == '0 && fetch_addr[ADDR_W-1:OFF] == $past(flush_addr[ADDR_W-1:OFF]));
endmodule

bind dual_pair_prefetch dual_pair_prefetch_chk #(.ADDR_W(ADDR_W), .OFF(OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .line_valid(line_valid), .br_taken(br_taken), .flush(flush),
  .flush_addr(flush_addr), .slot0_valid(slot0_valid), .slot1_valid(slot1_valid)
);

// File: tb/dual_pair_prefetch_test.sv
`timescale 1ns/1ps
module dual_pair_prefetch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] boot_addr = 32'h0000_1013;
  logic fetch_req;
  logic [31:0] fetch_addr;
  logic line_valid = 1'b0;
  logic [255:0] line_data;
  logic br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic flush = 1'b0;
  logic [31:0] flush_addr = '0;
  logic dec_ready = 1'b0;
  logic dec_single = 1'b0;
  logic [31:0] slot0, slot1;
  logic slot0_valid, slot1_valid;

  always #2 clk = ~clk;

  dual_pair_prefetch uut (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .line_valid(line_valid), .line_data(line_data),
    .br_taken(br_taken), .br_target(br_target),
    .flush(flush), .flush_addr(flush_addr),
    .dec_ready(dec_ready), .dec_single(dec_single),
    .slot0(slot0), .slot0_valid(slot0_valid),
    .slot1(slot1), .slot1_valid(slot1_valid)
  );

  always_comb
    for (int k = 0; k < 8; k++) line_data[k*32 +: 32] = {fetch_addr[31:5], 5'(k)};

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [31:0] q0[$], q1[$];
  bit m_act, m_fp, m_pend;
  logic [31:0] m_fa;

  function automatic int qsize(bit p);
    return p ? q1.size() : q0.size();
  endfunction
  function automatic logic [31:0] qat(bit p, int i);
    return p ? q1[i] : q0[i];
  endfunction

  task automatic chk(string name, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, name, got, exp);
    end
  endtask

  task automatic cyc(bit lv, bit br, logic [31:0] tgt, bit fl, logic [31:0] fa_in, bit rdy, bit single);
    bit exp_rv, acc;
    int sz, n;
    @(negedge clk);
    line_valid = lv; br_taken = br; br_target = tgt;
    flush = fl; flush_addr = fa_in; dec_ready = rdy; dec_single = single;
    #1;
    exp_rv = !fl && qsize(m_fp) <= 8;
    sz = qsize(m_act);
    chk("fetch_req", 32'(fetch_req), 32'(exp_rv));
    if (exp_rv) chk("fetch_addr", fetch_addr, m_fa);
    chk("slot0_valid", 32'(slot0_valid), 32'(sz >= 1));
    chk("slot1_valid", 32'(slot1_valid), 32'(sz >= 2));
    if (sz >= 1) chk("slot0", slot0, qat(m_act, 0));
    if (sz >= 2) chk("slot1", slot1, qat(m_act, 1));
    acc = exp_rv && lv;
    if (fl) begin
      q0.delete(); q1.delete();
      m_pend = 0; m_fp = m_act; m_fa = {fa_in[31:5], 5'b0};
    end else begin
      n = !rdy ? 0 : (single || sz < 2) ? (sz > 0 ? 1 : 0) : 2;
      for (int i = 0; i < n; i++) if (m_act) void'(q1.pop_front()); else void'(q0.pop_front());
      if (acc) begin
        for (int k = 0; k < 8; k++)
          if (m_fp) q1.push_back({m_fa[31:5], 5'(k)}); else q0.push_back({m_fa[31:5], 5'(k)});
        m_fa = m_fa + 32;
      end
      if (m_pend && sz == 0) begin
        m_act = m_fp; m_pend = 0;
      end else if (br && !m_pend) begin
        m_fp = !m_act; m_pend = 1; m_fa = {tgt[31:5], 5'b0};
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_act = 0; m_fp = 0; m_pend = 0; m_fa = {boot_addr[31:5], 5'b0};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tag = "R1"; cyc(0,0,0,0,0,0,0);
    tag = "R2"; repeat (2) cyc(1,0,0,0,0,0,0);
    tag = "R5"; repeat (3) cyc(1,0,0,0,0,0,0);
    tag = "R3"; repeat (4) cyc(0,0,0,0,0,1,0);
    tag = "R4"; repeat (3) cyc(0,0,0,0,0,1,1);
    cyc(0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,0,0);
    tag = "R3"; cyc(1,0,0,0,0,1,0);
    cyc(0,0,0,0,0,1,0);
    tag = "R6"; cyc(0,1,32'h0000_8a4c,0,0,0,0);
    cyc(1,0,0,0,0,1,0);
    cyc(1,0,0,0,0,0,0);
    tag = "R8"; cyc(0,1,32'h0000_f000,0,0,0,0);
    cyc(1,1,32'h0000_e000,0,0,1,1);
    tag = "R7"; repeat (10) cyc(0,0,0,0,0,1,0);
    tag = "R9"; cyc(1,0,0,0,0,0,0);
    cyc(0,1,32'h0000_2000,0,0,0,0);
    cyc(1,0,0,1,32'h0000_3337,0,0);
    cyc(0,0,0,0,0,1,0);
    cyc(1,0,0,0,0,1,0);
    tag = "R10"; cyc(1,1,32'h0000_5000,1,32'h0000_6010,1,0);
    cyc(1,0,0,0,0,1,0);
    cyc(0,0,0,0,0,1,1);
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r % 3 != 0, r < 4, $urandom, r == 99, $urandom, r % 4 != 0, r % 7 == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule